// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing front end of a serial memory that sits on a two-wire bus as a slave. It samples the raw clock and data lines on the system clock through synchronizers and detects start and stop conditions from the synchronized values. It shifts bytes in and out most significant bit first. It acknowledges on the ninth bus clock by enabling an open-drain pull-down; the line is never driven high.

After a start condition the first byte is an address byte. This byte holds a type field, device-select bits, upper memory address bits and the read/write flag. The select bits are compared with strap inputs, and a parameter mask inverts chosen strap positions before the compare. A matching address is reported to the memory-side controller on a one-cycle `sess_valid` pulse, which also carries the direction and the upper address bits. In a write, every received byte is handed over on `rx_valid` and acknowledged. In a read, the block asks for each byte with `tx_req`, samples `tx_data` in that same cycle, and keeps sending as long as the master acknowledges.

While the memory's internal program cycle runs (`busy` high), the block does not acknowledge its address, so a master can poll until the program cycle ends.

FSM states:
- `ST_IDLE`: waits for a start.
- `ST_ADDR`: receives the address byte.
- `ST_ADDR_ACK`: drives the address acknowledge.
- `ST_WR_DATA`: receives a data byte.
- `ST_WR_ACK`: drives the data acknowledge.
- `ST_RD_DATA`: sends a byte.
- `ST_RD_ACK`: samples the master's acknowledge.

FSM transitions:
- A stop in any state goes to `ST_IDLE`.
- A start in any state goes to `ST_ADDR`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a match, or to `ST_IDLE` otherwise.
- `ST_ADDR_ACK` goes to `ST_RD_DATA` or `ST_WR_DATA`, depending on the direction bit.
- `ST_WR_DATA` and `ST_WR_ACK` alternate.
- `ST_RD_DATA` goes to `ST_RD_ACK`.
- `ST_RD_ACK` goes back to `ST_RD_DATA` on a master acknowledge, or to `ST_IDLE` on a no-acknowledge.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset, `sda_pull`, `sess_valid`, `rx_valid`, `tx_req` and `bus_stop` are all low.
- R2: Start is data falling while clock is high, and stop is data rising while clock is high. Bus traffic before any start is never acknowledged. Every stop pulses `bus_stop` for one cycle.
- R3: The address byte layout is: bits [7:6] are the type field and must equal 2'b10; bits [5:4] are the select field; bits [3:1] are the upper address bits; bit 0 is the direction. The block acknowledges only when the select field equals `strap_sel ^ 2'b10`, i.e. bit 5 matches the inverted `strap_sel[1]`. On a mismatch it does not acknowledge and ignores everything until the next start.
- R4: On an accepted address, `sess_valid` pulses once, with `sess_rw` = bit 0 (1 = read, 0 = write) and `sess_hi` = bits [3:1].
- R5: In a write, each byte is received most significant bit first, presented on `rx_byte` with a one-cycle `rx_valid` pulse, and acknowledged on the ninth clock.
- R6: In a read, each byte is fetched by a one-cycle `tx_req` pulse (with `tx_data` sampled in that cycle) and sent most significant bit first. Another byte follows every master acknowledge.
- R7: A master no-acknowledge ends the read: the line stays released and no further `tx_req` is issued.
- R8: While `busy` is high, a matching address is not acknowledged and no session starts.
- R9: A stop in the middle of a byte aborts the transfer with no `rx_valid`. A start at any time, including a repeated start, restarts address reception.
- R10: `sda_pull` is high only during an acknowledge the slave gives, or a 0 data bit it sends. It is low during every bit driven by the master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| sda_pull | output | 1 | Pull-down enable for the data line |
| strap_sel | input | 2 | Device-select strap pins |
| busy | input | 1 | Internal program cycle in progress |
| sess_valid | output | 1 | Address accepted pulse |
| sess_rw | output | 1 | Direction of accepted session, 1 = read |
| sess_hi | output | 3 | Upper memory address bits from address byte |
| rx_valid | output | 1 | Received data byte pulse |
| rx_byte | output | 8 | Received data byte |
| tx_req | output | 1 | Request for next byte to send |
| tx_data | input | 8 | Byte to send, sampled when tx_req is high |
| bus_stop | output | 1 | Stop condition seen pulse |

## Verification
The hardest situations to reach from the ports are those where the bus ends a transfer at an unusual point. Examples are a stop after only half a data byte, and a repeated start that follows a data acknowledge. In both, the block must drop its bit count and hand nothing to the controller. The bench master task can stop after any number of bits, so it cuts a write off after four bits and then shows that the next address is still accepted. Acknowledge polling is reached by raising `busy` around a valid address and lowering it before a retry. Throughout, the bench compares the pull-down enable against its own bit-by-bit expectation on every clock while the bus clock is high.

// File: rtl/twi_pkg.sv
package twi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK
    } twi_state_e;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic q_prev
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-1:0], d};
    end

    assign q      = chain[STAGES-1];
    assign q_prev = chain[STAGES];
endmodule

// File: rtl/twi_addr_decode.sv
module twi_addr_decode #(
    parameter int                TYPE_W  = 2,
    parameter logic [TYPE_W-1:0] TYPE_ID = 2'b10,
    parameter int                SEL_W   = 2,
    parameter logic [SEL_W-1:0]  SEL_INV = 2'b10,
    parameter int                HI_W    = 3
) (
    input  logic [7:0]       addr_byte,
    input  logic [SEL_W-1:0] strap,
    input  logic             busy,
    output logic             hit,
    output logic             rw,
    output logic [HI_W-1:0]  hi
);
    localparam int HI_LO   = 1;
    localparam int SEL_LO  = HI_LO + HI_W;
    localparam int TYPE_LO = SEL_LO + SEL_W;

    always_comb begin
        rw  = addr_byte[0];
        hi  = addr_byte[HI_LO +: HI_W];
        hit = (addr_byte[TYPE_LO +: TYPE_W] == TYPE_ID)
           && (addr_byte[SEL_LO +: SEL_W] == (strap ^ SEL_INV))
           && !busy;
    end
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_pkg::*;
#(
    parameter int                TYPE_W      = 2,
    parameter logic [TYPE_W-1:0] TYPE_ID     = 2'b10,
    parameter int                SEL_W       = 2,
    parameter logic [SEL_W-1:0]  SEL_INV     = 2'b10,
    parameter int                HI_W        = 3,
    parameter int                SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_pull,
    input  logic [SEL_W-1:0] strap_sel,
    input  logic             busy,
    output logic             sess_valid,
    output logic             sess_rw,
    output logic [HI_W-1:0]  sess_hi,
    output logic             rx_valid,
    output logic [7:0]       rx_byte,
    output logic             tx_req,
    input  logic [7:0]       tx_data,
    output logic             bus_stop
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int LINES  = 2;

    twi_state_e        state, nxt;
    logic [LINES-1:0]  raw, syn, prv;
    logic              scl_s, sda_s, scl_p, sda_p;
    logic              start_ev, stop_ev, scl_rise, scl_fall;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              full, rw_q;
    logic              hit, dec_rw;
    logic [HI_W-1:0]   dec_hi;

    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        twi_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(raw[g]), .q(syn[g]), .q_prev(prv[g])
        );
    end

    assign {scl_s, sda_s} = syn;
    assign {scl_p, sda_p} = prv;
    assign start_ev = scl_s && scl_p && sda_p && !sda_s;
    assign stop_ev  = scl_s && scl_p && !sda_p && sda_s;
    assign scl_rise = scl_s && !scl_p;
    assign scl_fall = !scl_s && scl_p;
    assign full     = (cnt == CNT_W'(BYTE_W));

    twi_addr_decode #(
        .TYPE_W(TYPE_W), .TYPE_ID(TYPE_ID), .SEL_W(SEL_W),
        .SEL_INV(SEL_INV), .HI_W(HI_W)
    ) u_dec (
        .addr_byte(shreg), .strap(strap_sel), .busy(busy),
        .hit(hit), .rw(dec_rw), .hi(dec_hi)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_ev)       nxt = ST_IDLE;
        else if (start_ev) nxt = ST_ADDR;
        else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (scl_fall && full) nxt = hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) nxt = rw_q ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA:  if (scl_fall && full) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) nxt = ST_WR_DATA;
                ST_RD_DATA:  if (scl_fall && full) nxt = ST_RD_ACK;
                ST_RD_ACK: begin
                    if (scl_rise && sda_s) nxt = ST_IDLE;
                    else if (scl_fall)     nxt = ST_RD_DATA;
                end
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    assign tx_req = scl_fall && ((state == ST_ADDR_ACK && rw_q) || state == ST_RD_ACK);

    // shift register, bit counter and handover pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            cnt        <= '0;
            rw_q       <= 1'b0;
            sess_valid <= 1'b0;
            sess_rw    <= 1'b0;
            sess_hi    <= '0;
            rx_valid   <= 1'b0;
            rx_byte    <= '0;
            bus_stop   <= 1'b0;
        end else begin
            sess_valid <= 1'b0;
            rx_valid   <= 1'b0;
            bus_stop   <= stop_ev;
            if (start_ev || stop_ev) begin
                cnt <= '0;
            end else if (tx_req) begin
                shreg <= tx_data;
                cnt   <= '0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WR_DATA: begin
                        if (scl_rise && !full) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && full) begin
                            cnt <= '0;
                            if (state == ST_WR_DATA) begin
                                rx_valid <= 1'b1;
                                rx_byte  <= shreg;
                            end else if (hit) begin
                                rw_q       <= dec_rw;
                                sess_valid <= 1'b1;
                                sess_rw    <= dec_rw;
                                sess_hi    <= dec_hi;
                            end
                        end
                    end
                    ST_RD_DATA: begin
                        if (scl_rise && !full)      cnt   <= cnt + 1'b1;
                        else if (scl_fall && full)  cnt   <= '0;
                        else if (scl_fall)          shreg <= {shreg[BYTE_W-2:0], 1'b0};
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_pull = 1'b1;
            ST_RD_DATA:             sda_pull = !shreg[BYTE_W-1];
            default:                sda_pull = 1'b0;
        endcase
    end
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk
    import twi_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input twi_state_e state,
    input logic       sda_pull,
    input logic       sess_valid,
    input logic       busy,
    input logic       bus_stop,
    input logic       rx_valid,
    input logic       tx_req
);
    // R10: pull-down only in slave-driven phases
    p_pull_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> (state == ST_ADDR_ACK || state == ST_WR_ACK || state == ST_RD_DATA));

    // R8: no session while the program cycle is busy
    p_busy_nosess_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sess_valid |-> !$past(busy));

    // R9: a stop always leaves the machine idle
    p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |-> state == ST_IDLE);

    // R5: a handed-over byte is acknowledged
    p_rx_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> state == ST_WR_ACK);

    // R6: a fetched byte is sent next
    p_fetch_send_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> state == ST_RD_DATA);
endmodule

bind twi_mem_slave twi_mem_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .sda_pull(sda_pull),
    .sess_valid(sess_valid), .busy(busy), .bus_stop(bus_stop),
    .rx_valid(rx_valid), .tx_req(tx_req)
);

// File: tb/twi_mem_slave_test.sv
`timescale 1ns/100ps
module twi_mem_slave_test;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda_m = 1'b1, busy = 1'b0;
    logic       sda_line, sda_pull;
    logic [1:0] strap = 2'b01;
    logic       sess_valid, sess_rw, rx_valid, tx_req, bus_stop;
    logic [2:0] sess_hi;
    logic [7:0] rx_byte, tx_data;

    int checks = 0, failures = 0;
    int ptr = 0, rd_idx = 0, sess_cnt = 0, txreq_cnt = 0, stop_cnt = 0;
    logic       sess_rw_l = 1'b0;
    logic [2:0] sess_hi_l = '0;
    logic [7:0] rxq[$];
    logic       mon_en = 1'b0, exp_pull = 1'b0, done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;
    assign tx_data  = 8'(8'h3C + ptr * 29);

    twi_mem_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .sda_pull(sda_pull), .strap_sel(strap), .busy(busy),
        .sess_valid(sess_valid), .sess_rw(sess_rw), .sess_hi(sess_hi),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
        .tx_data(tx_data), .bus_stop(bus_stop)
    );

    // memory-side controller model
    always @(posedge clk) begin
        if (tx_req) begin ptr <= ptr + 1; txreq_cnt <= txreq_cnt + 1; end
        if (rx_valid) rxq.push_back(rx_byte);
        if (sess_valid) begin sess_cnt <= sess_cnt + 1; sess_rw_l <= sess_rw; sess_hi_l <= sess_hi; end
        if (bus_stop) stop_cnt <= stop_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison of the pull-down against the bit-level model (R10)
    always @(negedge clk) begin
        if (mon_en) chk(sda_pull === exp_pull, "R10", "pull per clock", int'(sda_pull), int'(exp_pull));
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b, input logic ep, output logic s);
        sda_m = b; tick(H);
        exp_pull = ep; mon_en = 1'b1; scl = 1'b1;
        tick(H / 2); s = sda_line; tick(H / 2);
        mon_en = 1'b0; scl = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H); scl = 1'b1; tick(H);
        sda_m = 1'b0; tick(H); scl = 1'b0; tick(H);
    endtask

    task automatic bus_stop_t();
        sda_m = 1'b0; tick(H); scl = 1'b1; tick(H);
        sda_m = 1'b1; tick(2 * H);
    endtask

    task automatic wr_byte(input logic [7:0] b, input logic ack, input string req);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(b[i], 1'b0, s);
        send_bit(1'b1, ack, s);
        chk(s == !ack, req, "ninth-clock line", int'(s), int'(!ack));
    endtask

    task automatic rd_byte(input logic mack, input string req);
        logic s;
        logic [7:0] got, exp;
        exp = 8'(8'h3C + rd_idx * 29);
        rd_idx++;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b1, !exp[i], s);
            got[i] = s;
        end
        chk(got == exp, req, "read byte", int'(got), int'(exp));
        send_bit(!mack, 1'b0, s);
    endtask

    initial begin
        int n0, s0;
        logic s;
        tick(5); rst_n = 1'b1; tick(2);
        // R1 reset state
        chk(!sda_pull && !sess_valid && !rx_valid && !tx_req && !bus_stop, "R1", "outputs after reset",
            int'({sda_pull, sess_valid, rx_valid, tx_req, bus_stop}), 0);

        // R2 traffic without a start is ignored
        scl = 1'b0; tick(H);
        wr_byte(8'hBA, 1'b0, "R2");
        bus_stop_t();
        chk(sess_cnt == 0, "R2", "no session before start", sess_cnt, 0);
        chk(stop_cnt == 1, "R2", "stop pulse count", stop_cnt, 1);

        // R3/R4/R5 write session: type 10, select 11 (strap 01), hi 101, write
        bus_start();
        wr_byte(8'hBA, 1'b1, "R3");
        chk(sess_cnt == 1 && sess_rw_l == 1'b0 && sess_hi_l == 3'd5, "R4", "write session fields",
            int'({sess_rw_l, sess_hi_l}), 5);
        wr_byte(8'h81, 1'b1, "R5");
        wr_byte(8'h7E, 1'b1, "R5");
        wr_byte(8'h00, 1'b1, "R5");
        bus_stop_t();
        chk(rxq.size() == 3, "R5", "received count", rxq.size(), 3);
        if (rxq.size() == 3) begin
            chk(rxq[0] == 8'h81, "R5", "byte0", int'(rxq[0]), 'h81);
            chk(rxq[1] == 8'h7E, "R5", "byte1", int'(rxq[1]), 'h7E);
            chk(rxq[2] == 8'h00, "R5", "byte2", int'(rxq[2]), 'h00);
        end

        // R3 select compared without the inversion: no ack, rest ignored
        n0 = rxq.size();
        bus_start();
        wr_byte(8'h9A, 1'b0, "R3");
        wr_byte(8'h55, 1'b0, "R3");
        bus_stop_t();
        chk(rxq.size() == n0, "R3", "bytes after mismatch", rxq.size(), n0);
        // R3 wrong type field
        bus_start();
        wr_byte(8'h3A, 1'b0, "R3");
        bus_stop_t();

        // R8 acknowledge polling while busy
        s0 = sess_cnt;
        busy = 1'b1;
        bus_start();
        wr_byte(8'hBA, 1'b0, "R8");
        bus_stop_t();
        chk(sess_cnt == s0, "R8", "no session while busy", sess_cnt, s0);
        busy = 1'b0;
        bus_start();
        wr_byte(8'hBA, 1'b1, "R8");
        bus_stop_t();

        // R6/R7 read session with hi 101
        txreq_cnt = 0;
        bus_start();
        wr_byte(8'hBB, 1'b1, "R6");
        chk(sess_rw_l == 1'b1 && sess_hi_l == 3'd5, "R4", "read session fields",
            int'({sess_rw_l, sess_hi_l}), 'hD);
        rd_byte(1'b1, "R6");
        rd_byte(1'b1, "R6");
        rd_byte(1'b0, "R7");
        send_bit(1'b1, 1'b0, s);
        chk(s == 1'b1, "R7", "line released after nack", int'(s), 1);
        bus_stop_t();
        chk(txreq_cnt == 3, "R7", "fetch count", txreq_cnt, 3);

        // R9 stop in the middle of a byte
        n0 = rxq.size();
        bus_start();
        wr_byte(8'hBA, 1'b1, "R9");
        for (int i = 0; i < 4; i++) send_bit(i[0], 1'b0, s);
        bus_stop_t();
        chk(rxq.size() == n0, "R9", "no byte after abort", rxq.size(), n0);
        bus_start();
        wr_byte(8'hBA, 1'b1, "R9");
        wr_byte(8'hC3, 1'b1, "R9");
        // R9 repeated start into a read
        bus_start();
        wr_byte(8'hB3, 1'b1, "R9");
        chk(sess_rw_l == 1'b1 && sess_hi_l == 3'd1, "R9", "repeated-start session",
            int'({sess_rw_l, sess_hi_l}), 'h9);
        rd_byte(1'b0, "R9");
        bus_stop_t();
        chk(rxq.size() == n0 + 1 && rxq[n0] == 8'hC3, "R9", "byte before repeated start",
            int'(rxq[rxq.size()-1]), 'hC3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL all-requirements watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule